// File: doc/BRIEF.md
# Asynchronous Static Memory Timing Engine

This block runs one asynchronous read or write at a time against SRAM, FRAM, PSRAM or NOR devices. The devices share one external bus. The internal side offers one request at a time. A request carries an address, a write flag, byte enables and write data. The top address bits pick one of up to four devices, and each device has its own active-low chip enable. When a read finishes, the block returns the read data together with a single-cycle done pulse. A write gives the same done pulse.

Each access moves through a fixed order of phases: byte-lane setup, address setup, address hold, data setup, data hold and bus turnaround. Each phase lasts a programmed number of clock cycles, and a count of zero removes the phase. Each device has its own timing words for reads and for writes. A per-device flag sends writes to the write word; with the flag clear, writes use the read timings. Two more per-device flags select a multiplexed address/data bus and let the wait input stretch the data setup phase.

Top module: `asm_timing_engine`

## Requirements
- R1: After reset all chip enables, output enable, write enable, address-valid and byte-lane enables are high (inactive), `req_ready` is 1 and `rsp_done` is 0.
- R2: Device index = `req_addr[AW-1:AW-2]`. During an access only `mem_ce_n[index]` goes low, and at no time is more than one chip enable low.
- R3: Byte enables go low (`mem_be_n = ~req_be`) for exactly `bls` cycles before the chip enable falls. Here `bls` is the device's 4-bit field `cfg_bls[dev*4 +: 4]`.
- R4: Address setup holds `mem_adv_n` low with the chip enable low for `ads` cycles. A timing word packs `{tat, dht, dst, adh, ads}`, 4 bits each, with `ads` in the lowest bits. Device d uses bits `d*20 +: 20`.
- R5: The address hold phase (chip enable low, `mem_adv_n` high, no strobe) lasts `adh` cycles only when `cfg_mux[dev]` = 1. In that mode the address is driven on `mem_dout` with `mem_doe` = 1 during address setup and address hold. With mux off the phase is skipped and `mem_doe` is 0 in the address phases.
- R6: Data setup pulls `mem_oe_n` (read) or `mem_we_n` (write) low for max(`dst`,1) cycles. On a write, `mem_dout` carries the write data with `mem_doe` = 1. The two strobes are never low together.
- R7: After the strobe, data hold keeps the chip enable low for `dht` cycles. Turnaround then keeps everything inactive for `tat` cycles. `req_ready` returns to 1 only after that, so the access takes the sum of all phase cycles.
- R8: A write to a device with `cfg_wsep` set uses that device's word in `cfg_wr_tim`. With the flag clear, writes use `cfg_rd_tim`.
- R9: With `cfg_await[dev]` = 1, every cycle `mem_wait` = 1 during data setup adds one cycle to it. With the flag clear, `mem_wait` has no effect.
- R10: Read data is `mem_din` as sampled on the clock edge that ends data setup. `rsp_done` is high for exactly one cycle, the cycle right after the last strobe cycle.
- R11: Zero-count phases are skipped. With all counts zero an access lasts one cycle, spent entirely in data setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Device index in top bits, device address below |
| req_be | input | DW/8 | Byte lanes to enable (active high) |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data |
| cfg_rd_tim | input | NCS*5*CW | Per-device read timing words |
| cfg_wr_tim | input | NCS*5*CW | Per-device write timing words |
| cfg_bls | input | NCS*CW | Per-device byte-lane setup count |
| cfg_mux | input | NCS | Per-device multiplexed address/data |
| cfg_await | input | NCS | Per-device wait stretching enable |
| cfg_wsep | input | NCS | Per-device write timing select |
| mem_ce_n | output | NCS | Chip enables, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DW/8 | Byte-lane enables, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_addr | output | AW-2 | Device address |
| mem_dout | output | DW | Data bus output value |
| mem_doe | output | 1 | Data bus drive enable |
| mem_din | input | DW | Data bus input value |
| mem_wait | input | 1 | Wait request, active high |

## Verification
The bench drives a request at a falling edge, and the request is taken on the next rising edge. The first phase is visible at the falling edge after that. The phase outputs decode the state register directly, so every phase lasts exactly its programmed count, and the bench classifies each sampled cycle by the pin levels alone. The done pulse and the read data come from registers loaded on the edge that ends data setup. They are therefore due in the cycle after the last strobe cycle, and the bench checks them there even when that cycle is already idle. Wait and read data are changed at the falling edge of each strobe cycle, so the edge-exact capture and the stretch count can be predicted from the strobe index.

// File: rtl/asm_timing_engine.sv
module asm_timing_engine #(
  parameter int AW  = 18,
  parameter int DW  = 16,
  parameter int NCS = 4,
  parameter int CW  = 4,
  localparam int SW  = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int EAW = AW - SW,
  localparam int BL  = DW / 8,
  localparam int TW  = 5 * CW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [BL-1:0]      req_be,
  input  logic [DW-1:0]      req_wdata,
  output logic               rsp_done,
  output logic [DW-1:0]      rsp_rdata,
  input  logic [NCS*TW-1:0]  cfg_rd_tim,
  input  logic [NCS*TW-1:0]  cfg_wr_tim,
  input  logic [NCS*CW-1:0]  cfg_bls,
  input  logic [NCS-1:0]     cfg_mux,
  input  logic [NCS-1:0]     cfg_await,
  input  logic [NCS-1:0]     cfg_wsep,
  output logic [NCS-1:0]     mem_ce_n,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic [BL-1:0]      mem_be_n,
  output logic               mem_adv_n,
  output logic [EAW-1:0]     mem_addr,
  output logic [DW-1:0]      mem_dout,
  output logic               mem_doe,
  input  logic [DW-1:0]      mem_din,
  input  logic               mem_wait
);
  localparam logic [2:0] PH_IDLE = 3'd0, PH_BLS = 3'd1, PH_ADS = 3'd2, PH_ADH = 3'd3,
                         PH_DST = 3'd4, PH_DHT = 3'd5, PH_TAT = 3'd6;

  logic [2:0]     ph, nxt;
  logic [CW-1:0]  cnt;
  logic [SW-1:0]  l_dev;
  logic           l_wr;
  logic [EAW-1:0] l_addr;
  logic [BL-1:0]  l_be;
  logic [DW-1:0]  l_wd;
  logic [CW-1:0]  dur [8];
  logic           found;

  wire           idle  = (ph == PH_IDLE);
  wire [SW-1:0]  s_dev = idle ? req_addr[AW-1 -: SW] : l_dev;
  wire           s_wr  = idle ? req_write : l_wr;
  wire [TW-1:0]  tim   = (s_wr && cfg_wsep[s_dev]) ? cfg_wr_tim[s_dev*TW +: TW]
                                                   : cfg_rd_tim[s_dev*TW +: TW];
  wire           stall = (ph == PH_DST) && cfg_await[l_dev] && mem_wait;

  always_comb begin
    dur[0] = '0;
    dur[1] = cfg_bls[s_dev*CW +: CW];
    dur[2] = tim[0 +: CW];
    dur[3] = cfg_mux[s_dev] ? tim[CW +: CW] : '0;
    dur[4] = (tim[2*CW +: CW] == '0) ? CW'(1) : tim[2*CW +: CW];
    dur[5] = tim[3*CW +: CW];
    dur[6] = tim[4*CW +: CW];
    dur[7] = '0;
  end

  always_comb begin
    nxt   = PH_IDLE;
    found = 1'b0;
    for (int p = 1; p < 7; p++) begin
      if (!found && (3'(p) > ph) && (dur[p] != '0)) begin
        nxt   = 3'(p);
        found = 1'b1;
      end
    end
  end

  wire [CW-1:0] nxt_cnt = (nxt == PH_IDLE) ? '0 : dur[nxt] - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      l_dev     <= '0;
      l_wr      <= 1'b0;
      l_addr    <= '0;
      l_be      <= '0;
      l_wd      <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      if (idle) begin
        if (req_valid) begin
          l_dev  <= s_dev;
          l_wr   <= req_write;
          l_addr <= req_addr[EAW-1:0];
          l_be   <= req_be;
          l_wd   <= req_wdata;
          ph     <= nxt;
          cnt    <= nxt_cnt;
        end
      end else if (!stall) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          ph  <= nxt;
          cnt <= nxt_cnt;
          if (ph == PH_DST) begin
            rsp_done <= 1'b1;
            if (!l_wr) rsp_rdata <= mem_din;
          end
        end
      end
    end
  end

  wire in_ce  = (ph == PH_ADS) || (ph == PH_ADH) || (ph == PH_DST) || (ph == PH_DHT);
  wire mux_a  = cfg_mux[l_dev] && ((ph == PH_ADS) || (ph == PH_ADH));
  wire drv_wd = l_wr && ((ph == PH_DST) || (ph == PH_DHT));

  assign req_ready = idle;
  assign mem_ce_n  = in_ce ? ~(NCS'(1) << l_dev) : '1;
  assign mem_be_n  = (!idle && ph != PH_TAT) ? ~l_be : '1;
  assign mem_adv_n = ~(ph == PH_ADS);
  assign mem_oe_n  = ~((ph == PH_DST) && !l_wr);
  assign mem_we_n  = ~((ph == PH_DST) && l_wr);
  assign mem_addr  = l_addr;
  assign mem_doe   = mux_a || drv_wd;
  assign mem_dout  = drv_wd ? l_wd : (mux_a ? DW'(l_addr) : '0);
endmodule

// File: rtl/asm_timing_engine_chk.sv
module asm_timing_engine_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           rsp_done,
  input logic [NCS-1:0] mem_ce_n,
  input logic           mem_oe_n,
  input logic           mem_we_n,
  input logic           mem_adv_n
);
  // R2
  ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_ce_n));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R4
  adv_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> ($countones(~mem_ce_n) == 1));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R10
  done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(!mem_oe_n || !mem_we_n));

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind asm_timing_engine asm_timing_engine_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_adv_n(mem_adv_n)
);

// File: tb/asm_timing_engine_tb.sv
module asm_timing_engine_tb;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_ready, req_write = 0;
  logic [17:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic [79:0] rd_tim = '0, wr_tim = '0;
  logic [15:0] bls = '0;
  logic [3:0]  mux = '0, await_en = '0, wsep = '0;
  logic [3:0]  mem_ce_n;
  logic        mem_oe_n, mem_we_n, mem_adv_n, mem_doe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_addr, mem_dout;
  logic [15:0] mem_din = '0;
  logic        mem_wait = 0;

  int checks = 0, errors = 0;
  int m_bls, m_ads, m_adh, m_dst, m_dht, m_tat, m_total, m_done, bad_ce, bad_mux, bad_wd, bad_done;
  logic [15:0] m_rd;

  always #10 clk = ~clk;

  asm_timing_engine u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .cfg_rd_tim(rd_tim), .cfg_wr_tim(wr_tim),
    .cfg_bls(bls), .cfg_mux(mux), .cfg_await(await_en), .cfg_wsep(wsep),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
    .mem_adv_n(mem_adv_n), .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe),
    .mem_din(mem_din), .mem_wait(mem_wait)
  );

  function automatic logic [19:0] tw(int ads, int adh, int dst, int dht, int tat);
    return {4'(tat), 4'(dht), 4'(dst), 4'(adh), 4'(ads)};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(int dev, bit wr, logic [15:0] a, logic [15:0] wd, int wcyc, logic [15:0] base);
    bit seen_ce = 0, seen_st = 0, prev_st = 0, st;
    m_bls = 0; m_ads = 0; m_adh = 0; m_dst = 0; m_dht = 0; m_tat = 0; m_total = 0;
    m_done = 0; bad_ce = 0; bad_mux = 0; bad_wd = 0; bad_done = 0; m_rd = '0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = {2'(dev), a}; req_be = 2'b11; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    for (int g = 0; g < 300; g++) begin
      if (rsp_done) begin
        m_done++; m_rd = rsp_rdata;
        if (!prev_st) bad_done++;
      end
      if (req_ready) break;
      m_total++;
      st = !mem_oe_n || !mem_we_n;
      if (!(&mem_ce_n)) begin
        seen_ce = 1;
        if (mem_ce_n != ~(4'b1 << dev)) bad_ce++;
      end
      if (!(&mem_be_n) && (&mem_ce_n) && !seen_ce) m_bls++;
      if (!mem_adv_n) m_ads++;
      if (!(&mem_ce_n) && mem_adv_n && !st) begin
        if (seen_st) m_dht++; else m_adh++;
      end
      if (!(&mem_ce_n) && !st && !seen_st) begin
        if (mux[dev] ? !(mem_doe && mem_dout == a) : mem_doe) bad_mux++;
      end
      if (st) begin
        seen_st = 1;
        mem_din = base + 16'(m_dst);
        mem_wait = (m_dst < wcyc);
        if (wr ? !(mem_doe && mem_dout == wd && !mem_we_n) : (mem_doe || mem_oe_n)) bad_wd++;
        m_dst++;
      end else mem_wait = 0;
      if (seen_ce && (&mem_ce_n) && (&mem_be_n)) m_tat++;
      prev_st = st;
      @(negedge clk);
    end
    mem_wait = 0;
  endtask

  task automatic t_reset;
    chk("R1 ce_n", mem_ce_n, 4'hF);
    chk("R1 strobes", {mem_oe_n, mem_we_n, mem_adv_n}, 3'b111);
    chk("R1 be_n", mem_be_n, 2'b11);
    chk("R1 ready", req_ready, 1);
    chk("R1 done", rsp_done, 0);
  endtask

  task automatic t_basic_read;
    bls[7:4] = 4'd2; rd_tim[20 +: 20] = tw(3, 2, 4, 1, 2); mux[1] = 0;
    run(1, 0, 16'h0123, 16'h0, 0, 16'h1000);
    chk("R3 bls cycles", m_bls, 2);
    chk("R4 ads cycles", m_ads, 3);
    chk("R5 no hold without mux", m_adh, 0);
    chk("R5 bus idle in address phase", bad_mux, 0);
    chk("R6 oe cycles", m_dst, 4);
    chk("R6 read bus released", bad_wd, 0);
    chk("R7 dht cycles", m_dht, 1);
    chk("R7 tat cycles", m_tat, 2);
    chk("R7 total", m_total, 12);
    chk("R10 rdata", m_rd, 16'h1003);
    chk("R10 one done after strobe", m_done * 10 + bad_done, 10);
    chk("R2 ce select", bad_ce, 0);
  endtask

  task automatic t_write_sep;
    bls[11:8] = 4'd1; rd_tim[40 +: 20] = tw(3, 0, 5, 3, 3); wr_tim[40 +: 20] = tw(1, 0, 2, 2, 1);
    wsep[2] = 1;
    run(2, 1, 16'h00A5, 16'hBEEF, 0, 16'h0);
    chk("R8 wr ads", m_ads, 1);
    chk("R8 wr dst", m_dst, 2);
    chk("R8 wr dht", m_dht, 2);
    chk("R8 wr tat", m_tat, 1);
    chk("R6 write data driven", bad_wd, 0);
    chk("R10 write done", m_done, 1);
    wsep[2] = 0;
    run(2, 1, 16'h00A6, 16'h1234, 0, 16'h0);
    chk("R8 shared ads", m_ads, 3);
    chk("R8 shared dst", m_dst, 5);
    chk("R8 shared total", m_total, 15);
  endtask

  task automatic t_mux;
    bls[15:12] = 4'd0; rd_tim[60 +: 20] = tw(2, 2, 1, 0, 1); mux[3] = 1;
    run(3, 0, 16'h3C5A, 16'h0, 0, 16'h2200);
    chk("R5 adh cycles", m_adh, 2);
    chk("R5 address on bus", bad_mux, 0);
    chk("R5 total", m_total, 6);
    chk("R10 mux rdata", m_rd, 16'h2200);
  endtask

  task automatic t_zero;
    bls[3:0] = 4'd0; rd_tim[0 +: 20] = tw(0, 0, 0, 0, 0);
    run(0, 0, 16'h0007, 16'h0, 0, 16'h4321);
    chk("R11 dst min one", m_dst, 1);
    chk("R11 total one", m_total, 1);
    chk("R11 no ads", m_ads, 0);
    chk("R10 done on idle", m_done * 10 + bad_done, 10);
    chk("R10 zero rdata", m_rd, 16'h4321);
  endtask

  task automatic t_wait;
    bls[7:4] = 4'd0; rd_tim[20 +: 20] = tw(1, 0, 2, 0, 0); await_en[1] = 1;
    run(1, 0, 16'h0011, 16'h0, 3, 16'h5000);
    chk("R9 stretched dst", m_dst, 5);
    chk("R9 stretched rdata", m_rd, 16'h5004);
    await_en[1] = 0;
    run(1, 0, 16'h0012, 16'h0, 3, 16'h6000);
    chk("R9 wait ignored", m_dst, 2);
    chk("R9 ignored rdata", m_rd, 16'h6001);
  endtask

  task automatic t_decode;
    for (int d = 0; d < 4; d++) begin
      mux[d] = 0; await_en[d] = 0;
      rd_tim[d*20 +: 20] = tw(1, 0, 1, 1, 0);
      run(d, 0, 16'h0100, 16'h0, 0, 16'h0);
      chk("R2 decode ce", bad_ce, 0);
      chk("R2 ce active cycles", m_ads + m_dst + m_dht, 3);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_basic_read();
    t_write_sep();
    t_mux();
    t_zero();
    t_wait();
    t_decode();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule